// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core that uses overlapping register windows. Software names 32 registers with a 5-bit index. The block turns each index into a location in a larger physical array, using two context inputs: the current window pointer and the global level. The two upper index bits pick a frame of eight registers: shared globals, outgoing, local or incoming. The three lower bits pick the register within that frame. The global level chooses one of three banks of globals. The window pointer chooses a pair of segments from a ring of 2×NWIN segments. A window's outgoing frame occupies the same storage as the incoming frame of the next window, so values pass between a caller and a callee without being copied.

The block has two combinational read ports and one write port that commits on the clock edge. It has a synchronous clear and a lookup output that reports the physical slot of any index. Changing either context input changes only which storage an index reaches. Stored contents stay where they are. An out-of-range context value is clamped to the highest legal value and raises an error flag.

The write port is a plain strobe with no ready signal. It accepts a write on every cycle, so the block applies no back-pressure. The read ports have no handshake and answer in the same cycle.

Top module: `rwin_regfile`

## Requirements
- R1: An index whose bits [4:3] are 0 reaches global bank `gl`. Its physical slot is gl×8 + idx[2:0], in the range 0..23.
- R2: For a window pointer c, the base segment b is ((NWIN − c) mod NWIN)×2. Index bits [4:3] = 1 (outgoing frame) use segment b. Bits [4:3] = 2 (locals) use segment b+1. Bits [4:3] = 3 (incoming frame) use segment (b+2) mod 2×NWIN. The physical slot is 24 + segment×8 + idx[2:0].
- R3: The three global banks hold separate values. A write to a global under one `gl` is not seen under another `gl`.
- R4: The outgoing frame of window c and the incoming frame of window (c+1) mod NWIN are the same storage. This includes the wrap from c = NWIN−1 to window 0.
- R5: Changing `cwp` or `gl` moves no data. A value written under one context reads back unchanged after the context leaves and returns.
- R6: A write takes effect at the clock edge. A read of the written register in the same cycle returns the old value, and the new value is visible from the next cycle.
- R7: With `clr` high at a clock edge, every register in every bank and segment becomes zero. A write in the same cycle is discarded.
- R8: A `gl` of 3 is treated as 2, and a `cwp` ≥ NWIN is treated as NWIN−1. `cfg_err` is high, combinationally, exactly while either input is out of range.
- R9: After reset, every register reads zero and `cfg_err` is low for legal context inputs.
- R10: The two read ports are independent. Each returns the register at its own index in the same cycle, and both return the same value when the indices match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; zeroes the storage |
| cwp | input | 5 | Current window pointer |
| gl | input | 2 | Global level (bank select) |
| cfg_err | output | 1 | High while `cwp` or `gl` is out of range |
| rd0_idx | input | 5 | Read port 0 architectural index |
| rd0_data | output | DW | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 architectural index |
| rd1_data | output | DW | Read port 1 data |
| wr_en | input | 1 | Write strobe; always accepted |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | DW | Write data |
| clr | input | 1 | Synchronous clear of all storage |
| map_idx | input | 5 | Index to translate |
| map_phys | output | clog2(24+16·NWIN) | Flattened physical slot of `map_idx` |

## Verification
A write and a read can address the same physical register in the same cycle. The bench provokes this by driving the write strobe and a read of the same index together. It expects the old value before the edge and the new value after it. A clear and a write can also meet on one edge. The bench raises both together and then sweeps every bank and window, expecting zeros everywhere and no trace of the discarded write. The window-aliasing check runs with a small window count, so the wrap from the last window to window 0 and the clamping of the window pointer are both reached.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int IDX_W    = 5;
  localparam int OFF_W    = 3;
  localparam int FRAME_SZ = 8;
  localparam int GL_BANKS = 3;
  localparam int GL_W     = 2;
  localparam int CWP_W    = 5;

  typedef enum logic [1:0] {
    FR_SHARED = 2'd0,
    FR_OUTGO  = 2'd1,
    FR_LOCAL  = 2'd2,
    FR_INCOME = 2'd3
  } frame_e;
endpackage

// File: rtl/rwin_ctx.sv
module rwin_ctx
  import rwin_pkg::*;
#(
  parameter int NWIN = 32
) (
  input  logic [CWP_W-1:0]                cwp,
  input  logic [GL_W-1:0]                 gl,
  output logic [GL_W-1:0]                 gl_eff,
  output logic [$clog2(2*NWIN)-1:0]       seg_out,
  output logic [$clog2(2*NWIN)-1:0]       seg_loc,
  output logic [$clog2(2*NWIN)-1:0]       seg_in,
  output logic                            cfg_err
);
  localparam int SEGS = 2 * NWIN;
  localparam int SW   = $clog2(SEGS);
  localparam logic [CWP_W:0] NWIN_X = (CWP_W+1)'(NWIN);
  localparam logic [SW:0]    SEGS_X = (SW+1)'(SEGS);
  localparam logic [GL_W-1:0] GL_MAX = GL_W'(GL_BANKS - 1);

  logic [CWP_W:0] cwp_x, cwp_c;
  logic           cwp_bad, gl_bad;
  logic [SW:0]    base, in_raw, in_w, loc_w;

  always_comb begin
    cwp_x   = {1'b0, cwp};
    cwp_bad = (cwp_x >= NWIN_X);
    gl_bad  = (gl > GL_MAX);
    cwp_c   = cwp_bad ? (NWIN_X - 1'b1) : cwp_x;
    gl_eff  = gl_bad ? GL_MAX : gl;
    base    = (cwp_c == '0) ? '0 : (SW+1)'({(NWIN_X - cwp_c), 1'b0});
    loc_w   = base + 1'b1;
    in_raw  = base + (SW+1)'(2);
    in_w    = (in_raw >= SEGS_X) ? (in_raw - SEGS_X) : in_raw;
    seg_out = base[SW-1:0];
    seg_loc = loc_w[SW-1:0];
    seg_in  = in_w[SW-1:0];
    cfg_err = cwp_bad | gl_bad;
  end
endmodule

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int NWIN = 32
) (
  input  logic [IDX_W-1:0]                                   idx,
  input  logic [GL_W-1:0]                                    gl_eff,
  input  logic [$clog2(2*NWIN)-1:0]                          seg_out,
  input  logic [$clog2(2*NWIN)-1:0]                          seg_loc,
  input  logic [$clog2(2*NWIN)-1:0]                          seg_in,
  output logic [$clog2(GL_BANKS*FRAME_SZ+2*NWIN*FRAME_SZ)-1:0] phys
);
  localparam int PW = $clog2(GL_BANKS*FRAME_SZ + 2*NWIN*FRAME_SZ);
  localparam int RW = PW - OFF_W;

  frame_e        fr;
  logic [RW-1:0] row;

  always_comb begin
    fr = frame_e'(idx[IDX_W-1:OFF_W]);
    unique case (fr)
      FR_SHARED: row = RW'(gl_eff);
      FR_OUTGO:  row = RW'(seg_out) + RW'(GL_BANKS);
      FR_LOCAL:  row = RW'(seg_loc) + RW'(GL_BANKS);
      default:   row = RW'(seg_in)  + RW'(GL_BANKS);
    endcase
    phys = {row, idx[OFF_W-1:0]};
  end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int DEPTH = 536,
  parameter int AW    = 10,
  parameter int DW    = 64,
  parameter int NRD   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NWIN = 32,
  parameter int DW   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          cwp,
  input  logic [1:0]          gl,
  output logic                cfg_err,
  input  logic [4:0]          rd0_idx,
  output logic [DW-1:0]       rd0_data,
  input  logic [4:0]          rd1_idx,
  output logic [DW-1:0]       rd1_data,
  input  logic                wr_en,
  input  logic [4:0]          wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                clr,
  input  logic [4:0]          map_idx,
  output logic [$clog2(GL_BANKS*FRAME_SZ+2*NWIN*FRAME_SZ)-1:0] map_phys
);
  localparam int DEPTH = GL_BANKS*FRAME_SZ + 2*NWIN*FRAME_SZ;
  localparam int PW    = $clog2(DEPTH);
  localparam int SW    = $clog2(2*NWIN);
  localparam int NRD   = 2;
  localparam int NQ    = NRD + 2;   // read ports, write port, lookup
  localparam int Q_WR  = NRD;
  localparam int Q_MAP = NRD + 1;

  logic [GL_W-1:0]  gl_eff;
  logic [SW-1:0]    seg_out, seg_loc, seg_in;
  logic [IDX_W-1:0] q_idx  [NQ];
  logic [PW-1:0]    q_phys [NQ];
  logic [PW-1:0]    rd_addr [NRD];
  logic [DW-1:0]    rd_val  [NRD];

  rwin_ctx #(.NWIN(NWIN)) u_ctx (
    .cwp     (cwp),
    .gl      (gl),
    .gl_eff  (gl_eff),
    .seg_out (seg_out),
    .seg_loc (seg_loc),
    .seg_in  (seg_in),
    .cfg_err (cfg_err)
  );

  assign q_idx[0]     = rd0_idx;
  assign q_idx[1]     = rd1_idx;
  assign q_idx[Q_WR]  = wr_idx;
  assign q_idx[Q_MAP] = map_idx;

  for (genvar q = 0; q < NQ; q++) begin : g_map
    rwin_map #(.NWIN(NWIN)) u_map (
      .idx     (q_idx[q]),
      .gl_eff  (gl_eff),
      .seg_out (seg_out),
      .seg_loc (seg_loc),
      .seg_in  (seg_in),
      .phys    (q_phys[q])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rdaddr
    assign rd_addr[p] = q_phys[p];
  end

  rwin_store #(.DEPTH(DEPTH), .AW(PW), .DW(DW), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .we    (wr_en),
    .waddr (q_phys[Q_WR]),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_val)
  );

  assign rd0_data = rd_val[0];
  assign rd1_data = rd_val[1];
  assign map_phys = q_phys[Q_MAP];
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int NWIN = 32,
  parameter int DW   = 64,
  parameter int PW   = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    cwp,
  input logic [1:0]    gl,
  input logic          cfg_err,
  input logic [4:0]    rd0_idx,
  input logic [DW-1:0] rd0_data,
  input logic [4:0]    rd1_idx,
  input logic [DW-1:0] rd1_data,
  input logic          wr_en,
  input logic [4:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          clr,
  input logic [4:0]    map_idx,
  input logic [PW-1:0] map_phys
);
  // R1
  glob_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_idx[4:3] == 2'd0 && gl != 2'd3) |->
      map_phys == (PW'(gl) * PW'(8) + PW'(map_idx[2:0])));

  // R6
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(clr) && $past(wr_idx) == rd0_idx &&
     $stable(cwp) && $stable(gl)) |-> rd0_data == $past(wr_data));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (rd0_data == '0 && rd1_data == '0));

  // R8
  gl_clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gl == 2'd3) |-> cfg_err);

  // R8
  legal_ctx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gl != 2'd3 && int'(cwp) < NWIN) |-> !cfg_err);

  // R10
  same_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == rd1_idx) |-> rd0_data == rd1_data);
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .DW(DW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cwp      (cwp),
  .gl       (gl),
  .cfg_err  (cfg_err),
  .rd0_idx  (rd0_idx),
  .rd0_data (rd0_data),
  .rd1_idx  (rd1_idx),
  .rd1_data (rd1_data),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .clr      (clr),
  .map_idx  (map_idx),
  .map_phys (map_phys)
);

// File: tb/rwin_regfile_test.sv
module rwin_regfile_test;
  localparam int NW = 6;
  localparam int DW = 32;
  localparam int PW = $clog2(24 + 16*NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    cwp = '0;
  logic [1:0]    gl = '0;
  logic          cfg_err;
  logic [4:0]    rd0_idx = '0, rd1_idx = '0, wr_idx = '0, map_idx = '0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic          wr_en = 1'b0, clr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [PW-1:0] map_phys;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rwin_regfile #(.NWIN(NW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cwp(cwp), .gl(gl), .cfg_err(cfg_err),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .clr(clr),
    .map_idx(map_idx), .map_phys(map_phys)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_phys(input int c, input int g, input int idx);
    int gg, cc, off, fr, b, seg;
    gg = (g > 2) ? 2 : g;
    cc = (c >= NW) ? NW - 1 : c;
    off = idx % 8;
    fr = idx / 8;
    if (fr == 0) return gg * 8 + off;
    b = (cc == 0) ? 0 : 2 * (NW - cc);
    seg = (fr == 1) ? b : (fr == 2) ? b + 1 : (b + 2) % (2 * NW);
    return 24 + seg * 8 + off;
  endfunction

  task automatic set_ctx(input int c, input int g);
    @(negedge clk);
    cwp = 5'(c);
    gl = 2'(g);
    #1;
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] d);
    rd0_idx = 5'(idx);
    #1;
    d = rd0_data;
  endtask

  task automatic t_reset;  // R9
    logic [DW-1:0] v;
    for (int i = 0; i < 32; i += 7) begin
      rd(i, v);
      chk("R9 reset zero", v, 0);
    end
    chk("R9 cfg_err low", cfg_err, 0);
  endtask

  task automatic t_globals;  // R1, R3
    logic [DW-1:0] v;
    for (int g = 0; g < 3; g++) begin
      set_ctx(0, g);
      wr(5, DW'(32'h100 + g));
    end
    for (int g = 0; g < 3; g++) begin
      set_ctx(3, g);
      rd(5, v);
      chk("R3 bank value", v, 64'(32'h100 + g));
      map_idx = 5'd5; #1;
      chk("R1 global slot", map_phys, 64'(exp_phys(3, g, 5)));
    end
  endtask

  task automatic t_window_map;  // R2
    for (int c = 0; c < NW; c++) begin
      set_ctx(c, 1);
      for (int i = 8; i < 32; i += 5) begin
        map_idx = 5'(i); #1;
        chk("R2 window slot", map_phys, 64'(exp_phys(c, 1, i)));
      end
    end
  endtask

  task automatic t_alias;  // R4
    logic [DW-1:0] v;
    logic [PW-1:0] po;
    for (int c = 0; c < NW; c++) begin
      set_ctx(c, 0);
      wr(8 + (c % 8), DW'(32'hA000 + c));
      map_idx = 5'(8 + (c % 8)); #1;
      po = map_phys;
      set_ctx((c + 1) % NW, 0);
      rd(24 + (c % 8), v);
      chk("R4 alias data", v, 64'(32'hA000 + c));
      map_idx = 5'(24 + (c % 8)); #1;
      chk("R4 alias slot", map_phys, 64'(po));
    end
  endtask

  task automatic t_context;  // R5
    logic [DW-1:0] v;
    set_ctx(2, 1);
    wr(18, 32'hBEEF_0012);
    set_ctx(4, 0);
    wr(18, 32'h0000_4444);
    set_ctx(2, 2);
    rd(18, v);
    chk("R5 local kept", v, 32'hBEEF_0012);
    rd(5, v);
    chk("R5 bank2 global kept", v, 32'h102);
  endtask

  task automatic t_rdw;  // R6
    logic [DW-1:0] v;
    set_ctx(1, 0);
    wr(3, 32'h1111);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'h2222; rd0_idx = 5'd3;
    #1;
    chk("R6 old value same cycle", rd0_data, 32'h1111);
    @(posedge clk); #1;
    chk("R6 new value next cycle", rd0_data, 32'h2222);
    @(negedge clk);
    wr_en = 1'b0;
    rd(3, v);
    chk("R6 value held", v, 32'h2222);
  endtask

  task automatic t_clear;  // R7
    logic [DW-1:0] v;
    int nz;
    set_ctx(0, 0);
    @(negedge clk);
    clr = 1'b1; wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hDEAD;
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    rd(9, v);
    chk("R7 write discarded under clear", v, 0);
    nz = 0;
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < NW; c++) begin
        cwp = 5'(c); gl = 2'(g);
        for (int i = 0; i < 32; i++) begin
          rd(i, v);
          if (v != 0) nz++;
        end
      end
    chk("R7 nonzero after clear", 64'(nz), 0);
  endtask

  task automatic t_clamp;  // R8
    logic [DW-1:0] v;
    set_ctx(0, 2);
    wr(6, 32'h6262);
    set_ctx(0, 3);
    chk("R8 gl flag", cfg_err, 1);
    rd(6, v);
    chk("R8 gl clamped data", v, 32'h6262);
    map_idx = 5'd2; #1;
    chk("R8 gl clamped slot", map_phys, 18);
    set_ctx(7, 0);
    chk("R8 cwp flag", cfg_err, 1);
    map_idx = 5'd8; #1;
    chk("R8 cwp clamped slot", map_phys, 64'(exp_phys(NW - 1, 0, 8)));
    set_ctx(NW - 1, 0);
    chk("R8 legal quiet", cfg_err, 0);
  endtask

  task automatic t_dual;  // R10
    set_ctx(3, 1);
    wr(20, 32'h2020);
    wr(1, 32'h0101);
    rd0_idx = 5'd20; rd1_idx = 5'd1; #1;
    chk("R10 port0", rd0_data, 32'h2020);
    chk("R10 port1", rd1_data, 32'h0101);
    rd1_idx = 5'd20; #1;
    chk("R10 same index", rd1_data, 32'h2020);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_globals();
    t_window_map();
    t_alias();
    t_context();
    t_rdw();
    t_clamp();
    t_dual();
    t_clear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule